// File: doc/BRIEF.md
# Crossbar Path Reservation Controller

This block is the central control unit of a non-blocking N x N crossbar whose data path is cut into byte-wide slices. The slices hold no arbitration logic of their own. They all follow one shared set of output-select settings, and this controller drives those settings. A source node that wants to send asks the controller for a path to one destination. The controller then replies in one of two ways: a grant once the destination output is reserved for that source, or an error when the request cannot be taken. The output stays tied to the source until the destination signals that it has received everything. The controller relays that completion to the source and frees the output.

The source may start sending only after its grant arrives. The slices run without a supervisor, so the whole exchange is paced by the sending node: request, grant, data, completion. Any set of distinct source-to-destination pairs can be held at once. When several pending sources want one free output, a rotating priority kept per output picks the winner. The losers stay pending until the path is released.

Top module: `xbar_resv_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all grant, error and done pulses are low and every output's enable is low.
- R2: A legal request sampled at clock edge k, naming a free output, produces a one-cycle grant pulse to the source after edge k+1. In that same cycle the output enable rises and the output's select field (bits d*IW of out_sel, IW = clog2(N)) holds the source index.
- R3: Requests from distinct sources to distinct free outputs, made in the same cycle, are all granted in the same cycle and held at the same time.
- R4: When several pending sources contend for one free output, the winner is the first pending source after the previous winner of that output, counting upward with wrap-around. After reset, the search starts at index 0.
- R5: A held output keeps its enable and select unchanged until the destination raises its completion input. The source then gets a one-cycle done pulse after the next edge.
- R6: The output is disabled in the cycle after the completion is sampled. A waiting source can be granted the output one cycle after that.
- R7: A request whose destination field (bits s*DW of req_dst, DW = clog2(N)+1) names the requester itself, or a value of N or above, gets a one-cycle error pulse after the next edge and never a grant.
- R8: A source holds at most one request or reservation. A request from a source that is already pending, or already holding a path that is not being released in that cycle, gets an error pulse and leaves the held path unchanged.
- R9: A completion input for an output that nobody holds is ignored: no pulse appears and no output's enable or select changes.
- R10: A source whose path is released in the same cycle that it makes a new legal request gets its done pulse and then a grant on the new path, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Per-source reservation request strobe |
| req_dst | input | N*DW | Per-source destination index, DW bits each |
| cpl_valid | input | N | Per-destination completion strobe from the receiving node |
| gnt_valid | output | N | Per-source grant pulse |
| err_valid | output | N | Per-source refusal pulse |
| done_valid | output | N | Per-source relayed completion pulse |
| out_en | output | N | Per-output path enable shared by all data slices |
| out_sel | output | N*IW | Per-output source select shared by all data slices |

## Verification
The hardest case to reach from the ports is a rotation of the per-output priority that is visibly not "lowest index wins". This needs a history of winners on one output together with a higher-numbered requester that is free at the right moment. The stimulus gets there in steps. Three sources queue on one output and are released one by one, so the pointer moves to 4. A path held by source 7 is then released, and sources 1 and 7 request the same output together. Source 7 must win. A release in the same cycle as a new request by the same source, and a completion strobe to an idle output, are also driven at exact cycles to reach the edge cases in R6, R9 and R10.

// File: rtl/xbar_resv_pkg.sv
package xbar_resv_pkg;

    // One-cycle reply pulses returned to a source node.
    typedef struct packed {
        logic err;
        logic gnt;
        logic done;
    } reply_t;

endpackage

// File: rtl/xbar_rr_pick.sv
module xbar_rr_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    // First requester strictly after ptr, wrapping around.
    always_comb begin
        int p;
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int off = 1; off <= N; off++) begin
            p = (int'(ptr) + off) % N;
            if (!any && req[p]) begin
                any    = 1'b1;
                gnt[p] = 1'b1;
                idx    = IW'(p);
            end
        end
    end

endmodule

// File: rtl/xbar_src_slot.sv
module xbar_src_slot
    import xbar_resv_pkg::*;
#(
    parameter int N   = 8,
    parameter int IDX = 0,
    parameter int IW  = (N > 1) ? $clog2(N) : 1,
    parameter int DW  = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [DW-1:0] req_dst,
    input  logic          win,
    input  logic          rel,
    output logic          pend,
    output logic [IW-1:0] pend_dst,
    output logic          hold,
    output reply_t        reply
);

    typedef struct packed {
        logic          pend;
        logic [IW-1:0] dst;
        logic          hold;
        reply_t        rsp;
    } src_state_t;

    src_state_t st_q, st_d;
    logic busy_c, illegal_c, accept_c;

    always_comb begin
        st_d      = st_q;
        busy_c    = st_q.pend | (st_q.hold & ~rel);
        illegal_c = (req_dst >= DW'(N)) || (req_dst == DW'(IDX));
        accept_c  = req_valid & ~busy_c & ~illegal_c;

        st_d.rsp.err  = req_valid & (busy_c | illegal_c);
        st_d.rsp.gnt  = win;
        st_d.rsp.done = rel;

        if (win) begin
            st_d.pend = 1'b0;
            st_d.hold = 1'b1;
        end else if (rel) begin
            st_d.hold = 1'b0;
        end

        if (accept_c) begin
            st_d.pend = 1'b1;
            st_d.dst  = req_dst[IW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend     = st_q.pend;
    assign pend_dst = st_q.dst;
    assign hold     = st_q.hold;
    assign reply    = st_q.rsp;

    AST_PEND_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.pend && st_q.hold)); // R8

    AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rsp.done |-> $past(st_q.hold)); // R5

    AST_ERR_NOT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rsp.err |-> !$rose(st_q.pend)); // R7

    AST_GNT_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rsp.gnt |-> $past(st_q.pend)); // R2

endmodule

// File: rtl/xbar_out_slot.sv
module xbar_out_slot #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_vec,
    input  logic          cpl,
    output logic [N-1:0]  win_vec,
    output logic          owned,
    output logic [IW-1:0] owner,
    output logic          rel
);

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] own;
        logic [IW-1:0] ptr;
    } out_state_t;

    out_state_t    st_q, st_d;
    logic [N-1:0]  pick_gnt;
    logic [IW-1:0] pick_idx;
    logic          pick_any;

    xbar_rr_pick #(.N(N), .IW(IW)) pick_i (
        .req (req_vec),
        .ptr (st_q.ptr),
        .gnt (pick_gnt),
        .idx (pick_idx),
        .any (pick_any)
    );

    always_comb begin
        st_d    = st_q;
        rel     = cpl & st_q.vld;
        win_vec = st_q.vld ? '0 : pick_gnt;
        if (rel) begin
            st_d.vld = 1'b0;
        end else if (!st_q.vld && pick_any) begin
            st_d.vld = 1'b1;
            st_d.own = pick_idx;
            st_d.ptr = pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= 1'b0;
            st_q.own <= '0;
            st_q.ptr <= IW'(N - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign owned = st_q.vld;
    assign owner = st_q.own;

    AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_vec)); // R4

    AST_OWNER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(st_q.vld)) |-> $stable(st_q.own)); // R5

    AST_FREE_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rel) |-> !st_q.vld); // R6

endmodule

// File: rtl/xbar_resv_ctrl.sv
module xbar_resv_ctrl
    import xbar_resv_pkg::*;
#(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int DW = IW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_valid,
    input  logic [N*DW-1:0] req_dst,
    input  logic [N-1:0]    cpl_valid,
    output logic [N-1:0]    gnt_valid,
    output logic [N-1:0]    err_valid,
    output logic [N-1:0]    done_valid,
    output logic [N-1:0]    out_en,
    output logic [N*IW-1:0] out_sel
);

    logic [N-1:0]  pend;
    logic [IW-1:0] pend_dst [N];
    logic [N-1:0]  hold;
    reply_t        reply    [N];
    logic [N-1:0]  win_src;
    logic [N-1:0]  rel_src;

    logic [N-1:0]  req_mat  [N];
    logic [N-1:0]  win_mat  [N];
    logic [N-1:0]  owned;
    logic [IW-1:0] owner    [N];
    logic [N-1:0]  rel_out;
    logic [N-1:0]  own_map  [N];

    always_comb begin
        for (int d = 0; d < N; d++) begin
            for (int s = 0; s < N; s++) begin
                req_mat[d][s] = pend[s] && (pend_dst[s] == IW'(d));
            end
        end
        win_src = '0;
        rel_src = '0;
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                own_map[s][d] = owned[d] && (owner[d] == IW'(s));
                win_src[s]    = win_src[s] | win_mat[d][s];
                rel_src[s]    = rel_src[s] | (rel_out[d] && (owner[d] == IW'(s)));
            end
        end
    end

    for (genvar s = 0; s < N; s++) begin : g_src
        xbar_src_slot #(.N(N), .IDX(s), .IW(IW), .DW(DW)) src_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[s]),
            .req_dst   (req_dst[s*DW +: DW]),
            .win       (win_src[s]),
            .rel       (rel_src[s]),
            .pend      (pend[s]),
            .pend_dst  (pend_dst[s]),
            .hold      (hold[s]),
            .reply     (reply[s])
        );
        assign gnt_valid[s]  = reply[s].gnt;
        assign err_valid[s]  = reply[s].err;
        assign done_valid[s] = reply[s].done;

        AST_ONE_PATH_PER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(own_map[s]) <= 1); // R8

        AST_HOLD_HAS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
            hold[s] |-> ($countones(own_map[s]) == 1)); // R5
    end

    for (genvar d = 0; d < N; d++) begin : g_out
        xbar_out_slot #(.N(N), .IW(IW)) out_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_vec (req_mat[d]),
            .cpl     (cpl_valid[d]),
            .win_vec (win_mat[d]),
            .owned   (owned[d]),
            .owner   (owner[d]),
            .rel     (rel_out[d])
        );
        assign out_en[d]            = owned[d];
        assign out_sel[d*IW +: IW]  = owner[d];
    end

endmodule

// File: tb/xbar_resv_ctrl_tb.sv
`timescale 1ns/1ps
module xbar_resv_ctrl_tb_top;

    localparam int N  = 8;
    localparam int IW = 3;
    localparam int DW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N*DW-1:0] req_dst = '0;
    logic [N-1:0]    cpl_valid = '0;
    logic [N-1:0]    gnt_valid, err_valid, done_valid, out_en;
    logic [N*IW-1:0] out_sel;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        int    c;
        int    node;
        int    kind;
        string tag;
    } exp_t;
    exp_t exq[$];

    xbar_resv_ctrl #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
        .cpl_valid(cpl_valid), .gnt_valid(gnt_valid), .err_valid(err_valid),
        .done_valid(done_valid), .out_en(out_en), .out_sel(out_sel)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ekey(int c, int node, int kind);
        return c * 1024 + node * 4 + kind;
    endfunction

    // kind: 0 error, 1 grant, 2 done
    function automatic void expect_ev(int c, int node, int kind, string tag);
        exp_t e;
        int pos;
        e.c = c; e.node = node; e.kind = kind; e.tag = tag;
        pos = exq.size();
        for (int j = 0; j < exq.size(); j++) begin
            if (ekey(exq[j].c, exq[j].node, exq[j].kind) > ekey(c, node, kind)) begin
                pos = j;
                break;
            end
        end
        exq.insert(pos, e);
    endfunction

    // Monitor: pops expected reply pulses as the design produces them.
    always @(negedge clk) begin
        logic obs;
        if (rst_n && !finished) begin
            for (int i = 0; i < N; i++) begin
                for (int k = 0; k < 3; k++) begin
                    obs = (k == 0) ? err_valid[i] : (k == 1) ? gnt_valid[i] : done_valid[i];
                    if (obs) begin
                        checks++;
                        if (exq.size() == 0) begin
                            errors++;
                            $display("FAIL unexpected: node %0d event %0d at cycle %0d, expected none", i, k, cyc);
                        end else if (exq[0].c != cyc || exq[0].node != i || exq[0].kind != k) begin
                            errors++;
                            $display("FAIL %s: node %0d event %0d at cycle %0d, expected node %0d event %0d at cycle %0d",
                                     exq[0].tag, i, k, cyc, exq[0].node, exq[0].kind, exq[0].c);
                        end else begin
                            void'(exq.pop_front());
                        end
                    end
                end
            end
            while (exq.size() > 0 && exq[0].c <= cyc) begin
                checks++;
                errors++;
                $display("FAIL %s: node %0d event %0d missing at cycle %0d, expected at cycle %0d",
                         exq[0].tag, exq[0].node, exq[0].kind, cyc, exq[0].c);
                void'(exq.pop_front());
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic req(int s, int d);
        req_valid[s] = 1'b1;
        req_dst[s*DW +: DW] = DW'(d);
    endtask

    task automatic step();
        @(negedge clk);
        req_valid = '0;
        req_dst   = '0;
        cpl_valid = '0;
    endtask

    function automatic int sel(int d);
        return int'(out_sel[d*IW +: IW]);
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 enables in reset", int'(out_en), 0);
        chk("R1 pulses in reset", int'(gnt_valid | err_valid | done_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 enables after reset", int'(out_en), 0);

        // R2: single grant timing and select
        req(0, 3); expect_ev(cyc + 2, 0, 1, "R2");
        step();
        chk("R2 enable not early", int'(out_en[3]), 0);
        step();
        chk("R2 enable", int'(out_en[3]), 1);
        chk("R2 select", sel(3), 0);

        // R7: self and out-of-range destinations
        req(4, 4); expect_ev(cyc + 1, 4, 0, "R7");
        req(5, 9); expect_ev(cyc + 1, 5, 0, "R7");
        step(); step();
        chk("R7 no path opened", int'(out_en[4]), 0);

        // R8: busy source refused, held path unchanged
        req(0, 6); expect_ev(cyc + 1, 0, 0, "R8");
        step(); step();
        chk("R8 no second path", int'(out_en[6]), 0);
        chk("R8 held path kept", int'(out_en[3]), 1);

        // R3: concurrent disjoint pairs
        req(5, 0); expect_ev(cyc + 2, 5, 1, "R3");
        req(6, 1); expect_ev(cyc + 2, 6, 1, "R3");
        req(7, 2); expect_ev(cyc + 2, 7, 1, "R3");
        step(); step();
        chk("R3 enables", int'(out_en[2:0]), 7);
        chk("R3 select 0", sel(0), 5);
        chk("R3 select 1", sel(1), 6);
        chk("R3 select 2", sel(2), 7);

        // R9: completion to an idle output
        cpl_valid[7] = 1'b1;
        step(); step();
        chk("R9 idle stays off", int'(out_en[7]), 0);
        chk("R9 enables unchanged", int'(out_en), 8'h0F);
        chk("R9 select unchanged", sel(3), 0);

        // R10: release and new request by the same source
        cpl_valid[3] = 1'b1; expect_ev(cyc + 1, 0, 2, "R10");
        req(0, 4);           expect_ev(cyc + 2, 0, 1, "R10");
        step();
        chk("R6 output freed", int'(out_en[3]), 0);
        step();
        chk("R10 new path", int'(out_en[4]), 1);
        chk("R10 select", sel(4), 0);

        // R4/R5/R6: contention on output 6
        req(1, 6); req(2, 6); req(4, 6); expect_ev(cyc + 2, 1, 1, "R4");
        step(); step();
        chk("R4 first winner", sel(6), 1);
        step();
        chk("R5 held stable", sel(6), 1);
        chk("R5 still enabled", int'(out_en[6]), 1);
        cpl_valid[6] = 1'b1; expect_ev(cyc + 1, 1, 2, "R5"); expect_ev(cyc + 2, 2, 1, "R6");
        step();
        chk("R6 off after release", int'(out_en[6]), 0);
        step();
        chk("R4 second winner", sel(6), 2);
        cpl_valid[6] = 1'b1; expect_ev(cyc + 1, 2, 2, "R5"); expect_ev(cyc + 2, 4, 1, "R4");
        step(); step();
        chk("R4 third winner", sel(6), 4);

        // R4: higher index beats lower after rotation
        cpl_valid[2] = 1'b1; expect_ev(cyc + 1, 7, 2, "R5");
        step();
        cpl_valid[6] = 1'b1; expect_ev(cyc + 1, 4, 2, "R5");
        req(1, 6); req(7, 6); expect_ev(cyc + 2, 7, 1, "R4");
        step(); step();
        chk("R4 rotation winner", sel(6), 7);
        cpl_valid[6] = 1'b1; expect_ev(cyc + 1, 7, 2, "R5"); expect_ev(cyc + 2, 1, 1, "R4");
        step(); step();
        chk("R4 waiter served", sel(6), 1);
        cpl_valid[6] = 1'b1; expect_ev(cyc + 1, 1, 2, "R5");
        step(); step(); step();
        chk("R5 all expected replies seen", exq.size(), 0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule